// File: doc/BRIEF.md
# CCD Electronic Shutter Controller

This block decides how long a CCD sensor collects charge in each field. It turns a shutter mode and a 9-bit load value into one of two things. In the short-exposure modes it becomes a count of lines at the top of the field during which the sensor discharge pulse fires. In the long-exposure mode it becomes a count of whole fields over which readout is held back. A separate sync counter supplies a field-start strobe, a line-start strobe and the current line number. The block returns a one-cycle `discharge` pulse for each line that must be cleared, and a `readout_en` qualifier that is high in every field whose charge may be read out.

The setting comes in one of two ways, chosen by `sel_serial`. In parallel mode it is taken from a 3-bit speed code and a 2-bit mode code on pins, and the speed code is mapped onto an equivalent load value. In serial mode a strobe/clock/data port shifts in a 12-bit word, which is then copied to a holding register. Whichever way is used, the resulting setting is sampled only at a field start, so a field never changes exposure part-way through.

The sequencer is a four-state machine that moves only on `field_start`. `S_OFF` fires no pulses and allows readout. `S_SHUT` fires the discharge pulses and allows readout. `S_LONG_ACC` is an accumulating long-exposure field, with no pulses and no readout. `S_LONG_READ` is the last field of a long exposure, with no pulses and readout allowed. The transitions are as follows. Mode off leads to `S_OFF`. Flickerless or high-speed leads to `S_SHUT`. Low-speed leads to `S_LONG_ACC`, coming from any state other than an unfinished `S_LONG_ACC`. `S_LONG_ACC` stays in `S_LONG_ACC` while the field index, plus one, is below N−1, and goes to `S_LONG_READ` when it reaches N−1. `S_LONG_READ` returns to `S_LONG_ACC` and restarts the field index at 0.

Top module: `ccd_shutter_ctrl`

## Requirements
- R1: After reset, `discharge` is 0 and `readout_en` is 1. The serial holding register contains mode 11 (off) with load value 0x1FE.
- R2: The mode code, written with the first mode bit as the MSB, selects the behaviour: 00 flickerless, 01 high-speed, 10 low-speed, 11 off.
- R3: In high-speed mode with load value L, `discharge` is high for exactly one cycle, one clock after each `line_start` whose `line_num` is below 0x1FF−L. No other line gets a pulse, and a `line_start` in the same cycle as `field_start` is ignored.
- R4: Flickerless mode behaves as high-speed mode with L = 0x149, so lines 0 to 181 are pulsed. In this mode the speed pins and the serial load value are ignored.
- R5: In off mode, no discharge pulses are produced and `readout_en` is 1 in every field.
- R6: In parallel high-speed mode, speed code c maps to these load values: 0 → 0x1FF (1/50 s, no pulses), 1 → 0x143, 2 → 0x105, 3 → 0x0E6, 4 → 0x0D6, 5 → 0x0CE, 6 → 0x0CA, 7 → 0x0C8.
- R7: In parallel low-speed mode, speed code c maps to load value 0x1FE−c, which gives an exposure of 2(c+1) fields.
- R8: In low-speed mode with load value L, an exposure spans N = 2·(0x1FF−L) fields. `readout_en` is 0 in the first N−1 fields and 1 in the last field, and then the pattern repeats. No discharge pulse fires in any of these fields.
- R9: In serial mode, `ser_dat` is shifted in on each rising edge of `ser_clk`. The bits arrive in the order D0…D8, then the first mode bit, then the second mode bit, then one dummy bit. A rising edge of `ser_stb` copies the word to the holding register; without that edge the held setting does not change.
- R10: When `sel_serial` is 1, the held serial mode and load value are used, and `mode_sel` and `spd_code` have no effect.
- R11: A load value of 0x1FF in low-speed mode is clamped to 0x1FE, which gives 2 fields.
- R12: A new setting is sampled only on `field_start`, so a change of the pins during a field does not alter that field. A serial strobe in the same cycle as `field_start` applies from the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_serial | input | 1 | 1 = serial setting, 0 = parallel pins |
| spd_code | input | 3 | Parallel speed code |
| mode_sel | input | 2 | Parallel mode code |
| ser_stb | input | 1 | Serial strobe; a rising edge loads the holding register |
| ser_clk | input | 1 | Serial clock; a rising edge shifts in a bit |
| ser_dat | input | 1 | Serial data |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| field_start | input | 1 | One-cycle strobe at the start of each field |
| line_num | input | LINE_W | Line index within the field, starting at 0 |
| discharge | output | 1 | Sensor discharge pulse |
| readout_en | output | 1 | Readout permitted in the current field |

## Verification
Two events can fall in the same clock: the serial strobe that loads a new setting, and the field start that samples the setting. The bench raises `ser_stb` in exactly the cycle of `field_start`, after first shifting in a word that differs from the held one. It then counts discharge pulses in that field and in the next one. The verdict is that the first field shows the old setting's pulse count and the second shows the new one. A pin change made in the middle of a field is judged the same way.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

    localparam int SH_LOAD_W = 9;

    typedef enum logic [1:0] {
        MD_FLICKER = 2'b00,
        MD_FAST    = 2'b01,
        MD_SLOW    = 2'b10,
        MD_OFF     = 2'b11
    } shut_mode_t;

    typedef enum logic [1:0] {
        S_OFF,
        S_SHUT,
        S_LONG_ACC,
        S_LONG_READ
    } expo_state_t;

    localparam logic [SH_LOAD_W-1:0] FLICKER_LOAD = 9'h149;

    // Parallel speed code to equivalent load value
    function automatic logic [SH_LOAD_W-1:0] par_load(input shut_mode_t m, input logic [2:0] c);
        logic [SH_LOAD_W-1:0] v;
        if (m == MD_SLOW) begin
            v = 9'h1FE - {6'd0, c};
        end else begin
            unique case (c)
                3'd0: v = 9'h1FF;
                3'd1: v = 9'h143;
                3'd2: v = 9'h105;
                3'd3: v = 9'h0E6;
                3'd4: v = 9'h0D6;
                3'd5: v = 9'h0CE;
                3'd6: v = 9'h0CA;
                default: v = 9'h0C8;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/shutter_serial_rx.sv
module shutter_serial_rx
    import shutter_pkg::*;
#(
    parameter int LOAD_W = SH_LOAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_stb,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [LOAD_W-1:0] held_load,
    output shut_mode_t        held_mode
);
    localparam int SER_W = LOAD_W + 3;

    logic             clk_d, stb_d;
    logic [SER_W-1:0] sr;
    logic             clk_rise, stb_rise;

    assign clk_rise = ser_clk & ~clk_d;
    assign stb_rise = ser_stb & ~stb_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d     <= 1'b0;
            stb_d     <= 1'b0;
            sr        <= '0;
            held_load <= {{(LOAD_W-1){1'b1}}, 1'b0};
            held_mode <= MD_OFF;
        end else begin
            clk_d <= ser_clk;
            stb_d <= ser_stb;
            if (clk_rise) begin
                sr <= {ser_dat, sr[SER_W-1:1]};
            end
            if (stb_rise) begin
                held_load <= sr[LOAD_W-1:0];
                held_mode <= shut_mode_t'({sr[LOAD_W], sr[LOAD_W+1]});
            end
        end
    end

    AST_HELD_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_rise |=> $stable(held_load) && $stable(held_mode)); // R9

endmodule

// File: rtl/shutter_setting_sel.sv
module shutter_setting_sel
    import shutter_pkg::*;
#(
    parameter int LOAD_W = SH_LOAD_W
) (
    input  logic              sel_serial,
    input  logic [2:0]        spd_code,
    input  logic [1:0]        mode_sel,
    input  logic [LOAD_W-1:0] held_load,
    input  shut_mode_t        held_mode,
    output shut_mode_t        pend_mode,
    output logic [LOAD_W-1:0] pend_span
);
    localparam logic [LOAD_W-1:0] ALL1 = '1;

    shut_mode_t        pin_mode;
    logic [LOAD_W-1:0] load_raw, load_eff;

    always_comb begin
        pin_mode  = shut_mode_t'(mode_sel);
        pend_mode = sel_serial ? held_mode : pin_mode;
        load_raw  = sel_serial ? held_load : par_load(pin_mode, spd_code);
        load_eff  = load_raw;
        if (pend_mode == MD_FLICKER) begin
            load_eff = FLICKER_LOAD;
        end else if (pend_mode == MD_SLOW && load_raw == ALL1) begin
            load_eff = ALL1 - LOAD_W'(1);
        end
        pend_span = ALL1 - load_eff;
    end

endmodule

// File: rtl/shutter_expo_fsm.sv
module shutter_expo_fsm
    import shutter_pkg::*;
#(
    parameter int LOAD_W = SH_LOAD_W,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  shut_mode_t        pend_mode,
    input  logic [LOAD_W-1:0] pend_span,
    output logic              discharge,
    output logic              readout_en
);
    localparam int CNT_W = LOAD_W + 1;
    localparam int CMP_W = (LINE_W > LOAD_W) ? LINE_W : LOAD_W;

    expo_state_t       state, state_nx;
    logic [LOAD_W-1:0] span_q;
    logic [CNT_W-1:0]  fcnt, fcnt_nx;
    logic [CNT_W-1:0]  nm1_new;

    assign nm1_new = {pend_span, 1'b0} - CNT_W'(1);

    always_comb begin
        state_nx = state;
        fcnt_nx  = fcnt;
        if (field_start) begin
            unique case (pend_mode)
                MD_OFF:               state_nx = S_OFF;
                MD_FAST, MD_FLICKER:  state_nx = S_SHUT;
                default: begin
                    if (state == S_LONG_ACC && (fcnt + CNT_W'(1)) >= nm1_new) begin
                        state_nx = S_LONG_READ;
                    end else if (state == S_LONG_ACC) begin
                        state_nx = S_LONG_ACC;
                        fcnt_nx  = fcnt + CNT_W'(1);
                    end else begin
                        state_nx = S_LONG_ACC;
                        fcnt_nx  = '0;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_OFF;
            fcnt   <= '0;
            span_q <= '0;
        end else begin
            state <= state_nx;
            fcnt  <= fcnt_nx;
            if (field_start) span_q <= pend_span;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            discharge <= 1'b0;
        end else begin
            discharge <= line_start && !field_start && (state == S_SHUT)
                         && (CMP_W'(line_num) < CMP_W'(span_q));
        end
    end

    always_comb readout_en = (state != S_LONG_ACC);

    AST_PULSE_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        discharge |-> $past(line_start)); // R3
    AST_STATE_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(state)); // R12
    AST_NO_PULSE_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        !readout_en |-> !discharge); // R8
    AST_OFF_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF) |=> !discharge); // R5
    AST_SLOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_mode == MD_SLOW) |-> (pend_span != '0)); // R11

endmodule

// File: rtl/ccd_shutter_ctrl.sv
module ccd_shutter_ctrl
    import shutter_pkg::*;
#(
    parameter int LOAD_W = SH_LOAD_W,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_serial,
    input  logic [2:0]        spd_code,
    input  logic [1:0]        mode_sel,
    input  logic              ser_stb,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              line_start,
    input  logic              field_start,
    input  logic [LINE_W-1:0] line_num,
    output logic              discharge,
    output logic              readout_en
);
    logic [LOAD_W-1:0] held_load, pend_span;
    shut_mode_t        held_mode, pend_mode;

    shutter_serial_rx #(.LOAD_W(LOAD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_stb   (ser_stb),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .held_load (held_load),
        .held_mode (held_mode)
    );

    shutter_setting_sel #(.LOAD_W(LOAD_W)) u_sel (
        .sel_serial (sel_serial),
        .spd_code   (spd_code),
        .mode_sel   (mode_sel),
        .held_load  (held_load),
        .held_mode  (held_mode),
        .pend_mode  (pend_mode),
        .pend_span  (pend_span)
    );

    shutter_expo_fsm #(.LOAD_W(LOAD_W), .LINE_W(LINE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .line_start  (line_start),
        .line_num    (line_num),
        .pend_mode   (pend_mode),
        .pend_span   (pend_span),
        .discharge   (discharge),
        .readout_en  (readout_en)
    );

endmodule

// File: tb/ccd_shutter_ctrl_tb.sv
module ccd_shutter_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 312;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_serial = 1'b0;
    logic [2:0] spd_code = 3'd0;
    logic [1:0] mode_sel = 2'b11;
    logic       ser_stb = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic       line_start = 1'b0, field_start = 1'b0;
    logic [9:0] line_num = '0;
    logic       discharge, readout_en;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int last_pulses, last_rd;
    int chg_line = -1;
    logic [2:0] chg_code = 3'd0;
    logic stb_at_start = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccd_shutter_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sel_serial(sel_serial), .spd_code(spd_code),
        .mode_sel(mode_sel), .ser_stb(ser_stb), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .line_start(line_start), .field_start(field_start), .line_num(line_num),
        .discharge(discharge), .readout_en(readout_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_field();
        last_pulses = 0;
        field_start = 1'b1;
        if (stb_at_start) ser_stb = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
        ser_stb = 1'b0;
        last_rd = int'(readout_en);
        for (int i = 0; i < LINES; i++) begin
            if (i == chg_line) spd_code = chg_code;
            line_start = 1'b1;
            line_num = 10'(i);
            @(negedge clk);
            line_start = 1'b0;
            if (discharge) last_pulses++;
            @(negedge clk);
            if (discharge) last_pulses = last_pulses + 1000;
        end
    endtask

    task automatic ser_send(input logic [8:0] ld, input logic [1:0] md);
        logic [11:0] w;
        w = {1'b0, md[0], md[1], ld};
        for (int b = 0; b < 12; b++) begin
            ser_dat = w[b];
            ser_clk = 1'b0;
            @(negedge clk);
            ser_clk = 1'b1;
            @(negedge clk);
        end
        ser_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic ser_strobe();
        ser_stb = 1'b1;
        @(negedge clk);
        ser_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 discharge", int'(discharge), 0);
        chk("R1 readout_en", int'(readout_en), 1);
        sel_serial = 1'b1;
        run_field();
        chk("R1 held off mode pulses", last_pulses, 0);
        chk("R1 held off mode readout", last_rd, 1);
        sel_serial = 1'b0;
    endtask

    task automatic t_parallel_fast();
        int exp_span[8] = '{0, 188, 250, 281, 297, 305, 309, 311};
        mode_sel = 2'b01;
        for (int c = 0; c < 8; c++) begin
            spd_code = 3'(c);
            run_field();
            chk($sformatf("R6 R3 code%0d pulses", c), last_pulses, exp_span[c]);
            chk("R2 fast readout", last_rd, 1);
        end
    endtask

    task automatic t_flicker();
        mode_sel = 2'b00;
        spd_code = 3'd7;
        run_field();
        chk("R4 flickerless pulses", last_pulses, 182);
    endtask

    task automatic t_off();
        mode_sel = 2'b11;
        for (int f = 0; f < 2; f++) begin
            run_field();
            chk("R5 off pulses", last_pulses, 0);
            chk("R5 off readout", last_rd, 1);
        end
    endtask

    task automatic t_parallel_slow();
        mode_sel = 2'b10;
        spd_code = 3'd1;
        for (int f = 0; f < 5; f++) begin
            run_field();
            chk($sformatf("R7 R8 field%0d readout", f), last_rd, (f == 3) ? 1 : 0);
            chk("R8 slow pulses", last_pulses, 0);
        end
    endtask

    task automatic t_serial_override();
        mode_sel = 2'b11;
        spd_code = 3'd0;
        ser_send(9'h1F0, 2'b01);
        ser_strobe();
        sel_serial = 1'b1;
        run_field();
        chk("R9 R10 serial fast pulses", last_pulses, 15);
        spd_code = 3'd5;
        mode_sel = 2'b10;
        run_field();
        chk("R10 pins ignored pulses", last_pulses, 15);
        ser_send(9'h0C8, 2'b01);
        run_field();
        chk("R9 no strobe no change", last_pulses, 15);
    endtask

    task automatic t_clamp();
        ser_send(9'h1FF, 2'b10);
        ser_strobe();
        for (int f = 0; f < 4; f++) begin
            run_field();
            chk($sformatf("R11 clamp field%0d readout", f), last_rd, (f % 2 == 1) ? 1 : 0);
        end
    endtask

    task automatic t_boundary();
        sel_serial = 1'b0;
        mode_sel = 2'b01;
        spd_code = 3'd2;
        run_field();
        chk("R12 settle", last_pulses, 250);
        chg_line = 5;
        chg_code = 3'd7;
        run_field();
        chg_line = -1;
        chk("R12 mid-field change ignored", last_pulses, 250);
        run_field();
        chk("R12 change at next field", last_pulses, 311);
        sel_serial = 1'b1;
        ser_send(9'h1F0, 2'b01);
        ser_strobe();
        run_field();
        chk("R12 serial base", last_pulses, 15);
        ser_send(9'h1E0, 2'b01);
        stb_at_start = 1'b1;
        run_field();
        stb_at_start = 1'b0;
        chk("R12 strobe with field start old", last_pulses, 15);
        run_field();
        chk("R12 strobe with field start new", last_pulses, 31);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_parallel_fast();
        t_flicker();
        t_off();
        t_parallel_slow();
        t_serial_override();
        t_clamp();
        t_boundary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule